// File: doc/BRIEF.md
# Supply Supervisor Reset Controller

This block generates the reset for a processor from a small set of supply-health flags and activity inputs. Digitized comparator flags report whether each of four candidate rails is above its reset threshold. One of the four is chosen at build time as the monitored rail. Index 3 is the input supply, and when it is chosen an undervoltage-lockout flag also forces reset. The block also watches two watchdog service inputs, each with its own timeout, and a manual reset input. Short low glitches on the manual reset input are filtered out.

The block has a single active-low reset output. It is driven low while any reset cause is present. After the last cause clears, it stays low for a fixed reset-active timeout before it is released. All asynchronous inputs pass through synchronizers before they are used. Every timeout is a parameter counted in clock cycles. The block's own power-on reset leaves the output asserted.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `por_n` is low and for at least TRP_CYCLES clocks after it rises, `rst_out_n` is 0.
- R2: A 0 on the selected rail flag `rail_ok[RAIL_SEL]` drives `rst_out_n` to 0 within 4 clocks.
- R3: Rail flags at indices other than RAIL_SEL have no effect on `rst_out_n`.
- R4: Once the last cause clears, `rst_out_n` stays 0 for at least TRP_CYCLES clocks and rises within TRP_CYCLES+4 clocks.
- R5: A cause that reappears while the timeout is counting keeps reset asserted, and the timeout restarts from the moment that cause clears.
- R6: With RAIL_SEL = 3, a 1 on `uvlo` asserts reset within 4 clocks even when `rail_ok[3]` is 1.
- R7: Any edge on `wdi[0]` services watchdog 1. If no edge arrives for WD1_CYCLES clocks, reset is asserted within WD1_CYCLES+5 clocks of the last edge.
- R8: Watchdog 2 behaves the same way on `wdi[1]` with WD2_CYCLES, independent of watchdog 1.
- R9: Both watchdog counters are held cleared while reset is asserted. An unserviced watchdog therefore fires no sooner than its timeout after reset is released.
- R10: When `mr_n` is held low for GLITCH_CYCLES or more clocks, reset is asserted and held while `mr_n` stays low. Reset is released TRP_CYCLES after `mr_n` returns high.
- R11: A low pulse on `mr_n` shorter than GLITCH_CYCLES clocks does not assert reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset of the block, active low |
| rail_ok | input | 4 | Comparator flags, 1 = that rail is above its threshold |
| uvlo | input | 1 | 1 = input supply is below the lockout level |
| wdi | input | 2 | Watchdog service inputs; any edge services |
| mr_n | input | 1 | Manual reset request, active low |
| rst_out_n | output | 1 | Processor reset, active low |

## Verification
The release timing is measured after each kind of cause: a brownout on the selected rail, a lockout event, a manual reset hold and each watchdog expiry. These measurements show whether every path feeds the same timeout stretch. Each unselected rail is toggled alone, and a manual pulse one clock shorter than the filter window is applied; these show whether the rail selection and the filter threshold are exact. Two further patterns stop one watchdog's service while the other keeps running, and interrupt the timeout with a second brownout. Together they distinguish the two watchdog timers, show that the counters are held during reset, and show that the timeout restarts.

// File: rtl/sup_pkg.sv
package sup_pkg;
    localparam int RAIL_COUNT        = 4;
    localparam int RAIL_INPUT_SUPPLY = 3;
    localparam int WD_COUNT          = 2;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                st_q.pipe[i] <= RST_VAL;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/sup_glitch_filter.sv
module sup_glitch_filter #(
    parameter int GLITCH_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_n_s_i,
    output logic mr_active_o
);
    localparam int CW = $clog2(GLITCH_CYCLES + 1);
    localparam logic [CW-1:0] FULL = CW'(GLITCH_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } gf_t;

    gf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mr_n_s_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != FULL) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mr_active_o = (st_q.cnt == FULL);

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);
    assert_accept_only_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mr_active_o) |-> $past(!mr_n_s_i));
    assert_high_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mr_n_s_i |=> !mr_active_o);
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
    parameter int WD_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic wdi_s_i,
    output logic expire_o
);
    localparam int CW = (WD_CYCLES > 1) ? $clog2(WD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WD_CYCLES - 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } wd_t;

    wd_t  st_d, st_q;
    logic serviced;

    always_comb begin
        st_d      = st_q;
        serviced  = (wdi_s_i != st_q.prev);
        st_d.prev = wdi_s_i;
        if (hold_i || serviced) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LAST) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expire_o = (st_q.cnt == LAST);

    assert_hold_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> st_q.cnt == '0);
    assert_fire_not_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expire_o) |-> !$past(hold_i));
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int RAIL_SEL      = 3,
    parameter int SYNC_STAGES   = 2,
    parameter int TRP_CYCLES    = 200,
    parameter int WD1_CYCLES    = 1600,
    parameter int WD2_CYCLES    = 3200,
    parameter int GLITCH_CYCLES = 8
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic [RAIL_COUNT-1:0] rail_ok,
    input  logic                  uvlo,
    input  logic [WD_COUNT-1:0]   wdi,
    input  logic                  mr_n,
    output logic                  rst_out_n
);
    localparam int SW = RAIL_COUNT + 2 + WD_COUNT;
    localparam logic [SW-1:0] SYNC_RST = {{RAIL_COUNT{1'b0}}, 1'b1, 1'b1, {WD_COUNT{1'b0}}};
    localparam int TW = (TRP_CYCLES > 1) ? $clog2(TRP_CYCLES) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(TRP_CYCLES - 1);
    localparam logic [1:0] SEL_IDX = RAIL_SEL[1:0];
    localparam bit WATCH_UVLO = (RAIL_SEL == RAIL_INPUT_SUPPLY);

    logic [RAIL_COUNT-1:0] rail_s;
    logic                  uvlo_s, mr_n_s;
    logic [WD_COUNT-1:0]   wdi_s, wd_exp;
    logic                  mr_active, cause;

    sup_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d_i   ({rail_ok, uvlo, mr_n, wdi}),
        .q_o   ({rail_s, uvlo_s, mr_n_s, wdi_s})
    );

    sup_glitch_filter #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_mr (
        .clk         (clk),
        .rst_n       (por_n),
        .mr_n_s_i    (mr_n_s),
        .mr_active_o (mr_active)
    );

    typedef struct packed {
        logic          hold;
        logic [TW-1:0] cnt;
    } rc_t;

    rc_t st_d, st_q;

    for (genvar g = 0; g < WD_COUNT; g++) begin : g_wd
        localparam int LIM = (g == 0) ? WD1_CYCLES : WD2_CYCLES;
        sup_watchdog #(.WD_CYCLES(LIM)) u_wd (
            .clk      (clk),
            .rst_n    (por_n),
            .hold_i   (st_q.hold),
            .wdi_s_i  (wdi_s[g]),
            .expire_o (wd_exp[g])
        );
    end

    always_comb begin
        cause = !rail_s[SEL_IDX] || (WATCH_UVLO && uvlo_s) || mr_active || (|wd_exp);
        st_d  = st_q;
        if (cause) begin
            st_d.hold = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.hold) begin
            if (st_q.cnt == T_LAST) begin
                st_d.hold = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.hold <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_out_n = !st_q.hold;

    assert_cause_asserts_R2: assert property (@(posedge clk) disable iff (!por_n)
        cause |=> !rst_out_n);
    assert_release_quiet_R4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_out_n) |-> $past(!cause));
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!por_n)
        st_q.cnt <= T_LAST);
    assert_idle_count_zero_R4: assert property (@(posedge clk) disable iff (!por_n)
        rst_out_n |-> st_q.cnt == '0);
endmodule

// File: tb/tb_sup_reset_ctrl.sv
module tb_sup_reset_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TRP = 40;
    localparam int WD1 = 100;
    localparam int WD2 = 160;
    localparam int GL  = 8;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [3:0] rail_ok = 4'hF;
    logic       uvlo = 1'b0;
    logic [1:0] wdi = 2'b00;
    logic       mr_n = 1'b1;
    logic       rst_out_n;
    logic [1:0] wd_en = 2'b11;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    sup_reset_ctrl #(.RAIL_SEL(3), .TRP_CYCLES(TRP), .WD1_CYCLES(WD1),
                     .WD2_CYCLES(WD2), .GLITCH_CYCLES(GL)) dut (
        .clk(clk), .por_n(por_n), .rail_ok(rail_ok), .uvlo(uvlo),
        .wdi(wdi), .mr_n(mr_n), .rst_out_n(rst_out_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            repeat (20) @(negedge clk);
            for (int i = 0; i < 2; i++) if (wd_en[i]) wdi[i] = ~wdi[i];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // cycles until rst_out_n equals lvl, or max+1 when it never does
    task automatic wait_out(input logic lvl, input int max, output int n);
        n = 0;
        while (rst_out_n !== lvl && n <= max) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic settle();
        int n;
        rail_ok = 4'hF; uvlo = 1'b0; mr_n = 1'b1; wd_en = 2'b11;
        wait_out(1'b1, 400, n);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_por();
        int n;
        repeat (3) @(negedge clk);
        check(rst_out_n === 1'b0, "R1 low in por", rst_out_n, 0);
        por_n = 1'b1;
        wait_out(1'b1, 400, n);
        check(n >= TRP && n <= TRP + 4, "R1 por release", n, TRP);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_rail();
        int n;
        rail_ok[3] = 1'b0;
        wait_out(1'b0, 20, n);
        check(n <= 4, "R2 rail low asserts", n, 3);
        repeat (10) @(negedge clk);
        check(rst_out_n === 1'b0, "R2 held while low", rst_out_n, 0);
        rail_ok[3] = 1'b1;
        wait_out(1'b1, 400, n);
        check(n >= TRP && n <= TRP + 4, "R4 release stretch", n, TRP);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_other_rails();
        for (int i = 0; i < 3; i++) begin
            int n;
            rail_ok[i] = 1'b0;
            wait_out(1'b0, 30, n);
            check(n > 30, "R3 unselected rail ignored", n, 31);
            rail_ok[i] = 1'b1;
        end
    endtask

    task automatic t_restart();
        int n;
        rail_ok[3] = 1'b0;
        repeat (6) @(negedge clk);
        rail_ok[3] = 1'b1;
        repeat (TRP / 2) @(negedge clk);
        rail_ok[3] = 1'b0;
        repeat (3) @(negedge clk);
        rail_ok[3] = 1'b1;
        wait_out(1'b1, 400, n);
        check(n >= TRP && n <= TRP + 4, "R5 timeout restarts", n, TRP);
        settle();
    endtask

    task automatic t_uvlo();
        int n;
        uvlo = 1'b1;
        wait_out(1'b0, 20, n);
        check(n <= 4, "R6 lockout asserts", n, 3);
        uvlo = 1'b0;
        wait_out(1'b1, 400, n);
        check(n >= TRP && n <= TRP + 4, "R6 lockout release", n, TRP);
        settle();
    endtask

    task automatic t_wd(input int idx, input int lim, input string req);
        int n;
        // wait for a fresh service edge on the watchdog, then stop it
        @(wdi[idx]);
        @(negedge clk);
        wd_en[idx] = 1'b0;
        wait_out(1'b0, lim + 40, n);
        check(n >= lim - 2 && n <= lim + 5, req, n, lim);
        wait_out(1'b1, 400, n);
        check(n >= TRP && n <= TRP + 4, "R4 release after watchdog", n, TRP);
        settle();
    endtask

    task automatic t_hold();
        int n;
        wd_en = 2'b10;
        rail_ok[3] = 1'b0;
        repeat (WD1 + 30) @(negedge clk);
        check(rst_out_n === 1'b0, "R9 reset held", rst_out_n, 0);
        rail_ok[3] = 1'b1;
        wait_out(1'b1, 400, n);
        wait_out(1'b0, WD1 + 40, n);
        check(n >= WD1 && n <= WD1 + 5, "R9 counter held during reset", n, WD1);
        settle();
    endtask

    task automatic t_mr();
        int n;
        mr_n = 1'b0;
        repeat (GL - 1) @(negedge clk);
        mr_n = 1'b1;
        wait_out(1'b0, 2 * GL + 10, n);
        check(n > 2 * GL + 10, "R11 short pulse ignored", n, 2 * GL + 11);
        mr_n = 1'b0;
        wait_out(1'b0, GL + 10, n);
        check(n >= GL && n <= GL + 4, "R10 long press asserts", n, GL + 3);
        repeat (TRP + 20) @(negedge clk);
        check(rst_out_n === 1'b0, "R10 held while low", rst_out_n, 0);
        mr_n = 1'b1;
        wait_out(1'b1, 400, n);
        check(n >= TRP && n <= TRP + 4, "R10 release after press", n, TRP);
        settle();
    endtask

    initial begin
        @(negedge clk);
        t_por();
        t_rail();
        t_other_rails();
        t_restart();
        t_uvlo();
        t_wd(0, WD1, "R7 watchdog 1 expiry");
        t_wd(1, WD2, "R8 watchdog 2 expiry");
        t_hold();
        t_mr();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(negedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired actual=0 expected=1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule